// File: doc/BRIEF.md
# Leveled Pending Interrupt Selector

This block keeps the interrupt requests that are waiting for service, sorted into eight priority levels (0 to 7). A requester posts a request by giving a level and an 8-bit vector number. Each level holds a small set of distinct vectors. The number of slots per level is a parameter.

At each instruction boundary the block compares what is waiting against the processor's current 3-bit priority. It then picks at most one request. The threshold for eligibility is not a simple "higher than current" rule:

- If the current priority is 3 or less, every level is eligible.
- Otherwise only levels strictly above the current priority are eligible.

Among the eligible levels, the lowest non-empty level wins. Inside that level, the numerically smallest vector is chosen.

The chosen vector and level are offered to the trap entry logic through a valid/ready pair. The level is passed along so that it can become the priority field of the new status word. The entry leaves storage only when the offer is accepted.

A small state machine controls the offer. It has two states:

| State | Behaviour | Leaves when | Goes to |
|---|---|---|---|
| `ST_IDLE` | No offer is shown. | A boundary strobe arrives and an eligible request exists (transition *launch*). The winner is latched at that point. | `ST_OFFER` |
| `ST_OFFER` | The latched vector and level are presented. | Ready is seen (transition *retire*). The entry is removed from its level on that edge. | `ST_IDLE` |

While in `ST_OFFER`, the state machine stays put (transition *hold*). Boundary strobes that arrive during `ST_OFFER` have no effect.

Top module: `irq_level_select`

## Requirements
- R1: A synchronous reset empties every level, clears the offer and clears the overflow flag. A boundary strobe given right after reset produces no offer.
- R2: The lowest eligible level depends on the current priority. At priority 0 to 3 it is level 0. At priority 4 to 7 it is the priority plus one, so priority 7 makes no level eligible.
- R3: Of the eligible levels, the lowest one that holds a request wins. Its level number appears on `sel_lvl`.
- R4: Within the winning level, the numerically smallest stored vector is offered on `sel_vec`.
- R5: Posting a vector that is already stored at the same level adds nothing. Only one acceptance is then needed to empty that entry. Duplicates are judged against the contents before any removal in the same cycle.
- R6: Once an offer is raised, `sel_valid` stays high and `sel_vec`/`sel_lvl` stay unchanged until `sel_ready` is seen. The entry is removed only on the accepting edge.
- R7: An offer appears only through a boundary strobe sampled in `ST_IDLE`. `sel_valid` rises on the clock edge that samples the strobe, and at most one request is offered per boundary.
- R8: A post of a new vector to a level that already holds DEPTH vectors is dropped. `ovf_pulse` is then high for the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| post_en | input | 1 | Post strobe for a new request |
| post_lvl | input | 3 | Level of the posted request |
| post_vec | input | 8 | Vector of the posted request |
| cur_pri | input | 3 | Current processor priority |
| boundary | input | 1 | Instruction boundary strobe |
| sel_valid | output | 1 | A request is offered |
| sel_lvl | output | 3 | Level of the offered request |
| sel_vec | output | 8 | Vector of the offered request |
| sel_ready | input | 1 | Trap entry logic accepts the offer |
| ovf_pulse | output | 1 | A post was dropped because its level was full |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Eligibility threshold.** Priorities 3, 4 and 7 are tested. An off-by-one in the threshold would offer a level equal to the priority, or would lock out level 0 at priority 3.
- **Duplicate post.** A vector is posted twice. A selector that stored duplicates would offer it a second time.
- **Smaller vector during an offer.** A smaller vector is posted while an offer is being held. A design that re-evaluates during the hold would change `sel_vec` under a waiting consumer.
- **Full level.** A level is filled and then posted to again. A missing full check would overwrite a stored vector, and a missing flag would hide the loss.

Random traffic with a narrow vector range drives duplicates, posts in the same cycle as an acceptance, and priority changes against a bench-side set model.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } sel_state_t;
endpackage

// File: rtl/irq_sel_level.sv
module irq_sel_level #(
    parameter int DEPTH = 4,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_en,
    input  logic [VEC_W-1:0] ins_vec,
    input  logic             rem_en,
    input  logic [VEC_W-1:0] rem_vec,
    output logic             nonempty,
    output logic [VEC_W-1:0] min_vec,
    output logic             drop
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] slot_v;
    logic [DEPTH-1:0] slot_v_nxt;
    logic [VEC_W-1:0] slot_d [DEPTH];
    logic             hit;
    logic             full;
    logic             have_free;
    logic [IDX_W-1:0] free_idx;
    logic             do_ins;

    // Duplicate search and first free slot
    always_comb begin
        hit       = 1'b0;
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_v[i] && slot_d[i] == ins_vec) hit = 1'b1;
            if (!slot_v[i] && !have_free) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    assign full   = &slot_v;
    assign drop   = ins_en && !hit && full;
    assign do_ins = ins_en && !hit && have_free;

    // Smallest stored vector
    always_comb begin
        nonempty = 1'b0;
        min_vec  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_v[i] && (!nonempty || slot_d[i] < min_vec)) begin
                nonempty = 1'b1;
                min_vec  = slot_d[i];
            end
        end
    end

    // Occupancy update: insert into a free slot, clear on matching removal
    always_comb begin
        slot_v_nxt = slot_v;
        if (do_ins) slot_v_nxt[free_idx] = 1'b1;
        if (rem_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (slot_v[i] && slot_d[i] == rem_vec) slot_v_nxt[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_v <= '0;
        else     slot_v <= slot_v_nxt;
    end

    always_ff @(posedge clk) begin
        if (do_ins) slot_d[free_idx] <= ins_vec;
    end

    // R8: a dropped post leaves the level untouched
    p_drop_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (drop && !rem_en) |=> $stable(slot_v));

    // R5: posting a stored vector leaves the level untouched
    p_dup_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (ins_en && hit && !rem_en) |=> $stable(slot_v));
endmodule

// File: rtl/irq_sel_arbiter.sv
module irq_sel_arbiter #(
    parameter int NUM_LVL  = 8,
    parameter int LVL_W    = 3,
    parameter int OPEN_MAX = 3
) (
    input  logic [NUM_LVL-1:0] lvl_busy,
    input  logic [LVL_W-1:0]   cur_pri,
    output logic               found,
    output logic [LVL_W-1:0]   win_lvl
);
    logic [LVL_W:0] start_lvl;

    always_comb begin
        if (int'(cur_pri) <= OPEN_MAX) start_lvl = '0;
        else                           start_lvl = {1'b0, cur_pri} + 1'b1;
    end

    // Scan from the top down so the lowest eligible level is left standing
    always_comb begin
        found   = 1'b0;
        win_lvl = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (lvl_busy[i] && (i >= int'(start_lvl))) begin
                found   = 1'b1;
                win_lvl = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_level_select.sv
module irq_level_select
    import irq_sel_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int VEC_W    = 8,
    parameter int NUM_LVL  = 8,
    parameter int OPEN_MAX = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       post_en,
    input  logic [$clog2(NUM_LVL)-1:0] post_lvl,
    input  logic [VEC_W-1:0]           post_vec,
    input  logic [$clog2(NUM_LVL)-1:0] cur_pri,
    input  logic                       boundary,
    output logic                       sel_valid,
    output logic [$clog2(NUM_LVL)-1:0] sel_lvl,
    output logic [VEC_W-1:0]           sel_vec,
    input  logic                       sel_ready,
    output logic                       ovf_pulse
);
    localparam int LVL_W = $clog2(NUM_LVL);

    sel_state_t       state_q, state_d;
    logic [LVL_W-1:0] lvl_q;
    logic [VEC_W-1:0] vec_q;
    logic             ovf_q;
    logic             launch;
    logic             retire;

    logic [NUM_LVL-1:0] busy;
    logic [NUM_LVL-1:0] drops;
    logic [VEC_W-1:0]   lvl_min [NUM_LVL];
    logic               found;
    logic [LVL_W-1:0]   win_lvl;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        irq_sel_level #(.DEPTH(DEPTH), .VEC_W(VEC_W)) u_level (
            .clk      (clk),
            .rst      (rst),
            .ins_en   (post_en && (post_lvl == LVL_W'(g))),
            .ins_vec  (post_vec),
            .rem_en   (retire && (lvl_q == LVL_W'(g))),
            .rem_vec  (vec_q),
            .nonempty (busy[g]),
            .min_vec  (lvl_min[g]),
            .drop     (drops[g])
        );
    end

    irq_sel_arbiter #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .OPEN_MAX(OPEN_MAX)) u_arb (
        .lvl_busy (busy),
        .cur_pri  (cur_pri),
        .found    (found),
        .win_lvl  (win_lvl)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        retire  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (boundary && found) begin
                    launch  = 1'b1;
                    state_d = ST_OFFER;
                end
            end
            ST_OFFER: begin
                if (sel_ready) begin
                    retire  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Latched offer and overflow flag
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            vec_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= |drops;
            if (launch) begin
                lvl_q <= win_lvl;
                vec_q <= lvl_min[win_lvl];
            end
        end
    end

    // Outputs
    always_comb begin
        sel_valid = (state_q == ST_OFFER);
        sel_lvl   = lvl_q;
        sel_vec   = vec_q;
        ovf_pulse = ovf_q;
    end

    // R6: offer held steady until accepted
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && !sel_ready) |=> (sel_valid && $stable(sel_vec) && $stable(sel_lvl)));

    // R6: accept ends the offer
    p_accept_r6: assert property (@(posedge clk) disable iff (rst)
        (sel_valid && sel_ready) |=> !sel_valid);

    // R7: an offer rises only from a sampled boundary
    p_from_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_valid) |-> $past(boundary));

    // R2: the offered level was eligible under the priority at launch
    p_eligible_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_valid) |-> ((int'($past(cur_pri)) <= OPEN_MAX) || (sel_lvl > $past(cur_pri))));
endmodule

// File: tb/irq_level_select_test.sv
module irq_level_select_test;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       post_en = 1'b0;
    logic [2:0] post_lvl = '0;
    logic [7:0] post_vec = '0;
    logic [2:0] cur_pri = '0;
    logic       boundary = 1'b0;
    logic       sel_ready = 1'b0;
    logic       sel_valid;
    logic [2:0] sel_lvl;
    logic [7:0] sel_vec;
    logic       ovf_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    irq_level_select #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .post_en(post_en), .post_lvl(post_lvl),
        .post_vec(post_vec), .cur_pri(cur_pri), .boundary(boundary),
        .sel_valid(sel_valid), .sel_lvl(sel_lvl), .sel_vec(sel_vec),
        .sel_ready(sel_ready), .ovf_pulse(ovf_pulse)
    );

    // Set model of the pending requests
    bit mq [8][256];
    int mcnt [8];
    bit moff;
    int mlvl, mvec;
    bit movf;

    function automatic void model_pick(input int pri, output bit f, output int l, output int v);
        int start;
        start = (pri <= 3) ? 0 : pri + 1;
        f = 0; l = 0; v = 0;
        for (int i = start; i < 8 && !f; i++) begin
            for (int j = 0; j < 256 && !f; j++) begin
                if (mq[i][j]) begin f = 1; l = i; v = j; end
            end
        end
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        bit f; int l, v;
        @(posedge clk);
        cycles++;
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                mcnt[i] = 0;
                for (int j = 0; j < 256; j++) mq[i][j] = 0;
            end
            moff = 0; movf = 0;
        end else begin
            bit rem; int rl, rv;
            rem = 0; rl = 0; rv = 0;
            if (!moff && boundary) begin
                model_pick(int'(cur_pri), f, l, v);
                if (f) begin moff = 1; mlvl = l; mvec = v; end
            end else if (moff && sel_ready) begin
                rem = 1; rl = mlvl; rv = mvec; moff = 0;
            end
            movf = 0;
            if (post_en) begin
                if (mq[post_lvl][post_vec]) ;
                else if (mcnt[post_lvl] == DEPTH) movf = 1;
                else begin mq[post_lvl][post_vec] = 1; mcnt[post_lvl]++; end
            end
            if (rem && mq[rl][rv]) begin mq[rl][rv] = 0; mcnt[rl]--; end
        end
        #1;
        chk(sel_valid == moff, "R7 valid", sel_valid, moff);
        if (moff) begin
            chk(int'(sel_lvl) == mlvl, "R3 level", sel_lvl, mlvl);
            chk(int'(sel_vec) == mvec, "R4 vector", sel_vec, mvec);
        end
        chk(ovf_pulse == movf, "R8 overflow", ovf_pulse, movf);
    endtask

    task automatic post(input int l, input int v);
        post_en = 1; post_lvl = 3'(l); post_vec = 8'(v);
        tick();
        post_en = 0;
    endtask

    task automatic bnd(input int pri);
        cur_pri = 3'(pri); boundary = 1;
        tick();
        boundary = 0;
    endtask

    task automatic take();
        sel_ready = 1;
        tick();
        sel_ready = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst = 0;
        tick();
        // R1: empty after reset
        chk(sel_valid == 0, "R1 valid after reset", sel_valid, 0);
        chk(ovf_pulse == 0, "R1 ovf after reset", ovf_pulse, 0);
        bnd(0);
        chk(sel_valid == 0, "R1 no offer when empty", sel_valid, 0);

        // R3 / R4: lowest level, smallest vector
        post(5, 8'h40); post(5, 8'h10); post(2, 8'h33);
        bnd(0);
        chk(sel_valid && sel_lvl == 2 && sel_vec == 8'h33, "R3 lowest level", {sel_lvl, sel_vec}, {3'd2, 8'h33});
        take();
        bnd(1);
        chk(sel_lvl == 5 && sel_vec == 8'h10, "R4 smallest vector", sel_vec, 8'h10);
        take();
        bnd(1);
        chk(sel_vec == 8'h40, "R4 next vector", sel_vec, 8'h40);
        take();

        // R2: irregular threshold
        post(3, 8'h03); post(4, 8'h04);
        bnd(4);
        chk(sel_valid == 0, "R2 pri4 blocks levels 3 and 4", sel_valid, 0);
        post(5, 8'h07);
        bnd(4);
        chk(sel_valid && sel_lvl == 5, "R2 pri4 admits level 5", sel_lvl, 5);
        take();
        post(7, 8'h77);
        bnd(7);
        chk(sel_valid == 0, "R2 pri7 blocks all", sel_valid, 0);
        bnd(3);
        chk(sel_valid && sel_lvl == 3, "R2 pri3 admits level 3", sel_lvl, 3);
        take();
        bnd(0);
        chk(sel_lvl == 4, "R2 level 4 next", sel_lvl, 4);
        take();
        bnd(0);
        chk(sel_lvl == 7, "R2 level 7 next", sel_lvl, 7);
        take();

        // R5: duplicate post
        post(1, 8'h22); post(1, 8'h22);
        bnd(0);
        take();
        bnd(0);
        chk(sel_valid == 0, "R5 duplicate not stored", sel_valid, 0);

        // R6: offer held, later smaller vector waits
        post(1, 8'h20);
        bnd(0);
        post(1, 8'h05);
        tick(); tick();
        chk(sel_valid && sel_vec == 8'h20, "R6 held vector", sel_vec, 8'h20);
        bnd(0);
        chk(sel_vec == 8'h20, "R7 boundary ignored while offering", sel_vec, 8'h20);
        take();
        chk(sel_valid == 0, "R6 accept clears", sel_valid, 0);
        bnd(0);
        chk(sel_vec == 8'h05, "R6 removal only on accept", sel_vec, 8'h05);
        take();

        // R8: full level
        for (int k = 1; k <= DEPTH; k++) post(6, k);
        chk(ovf_pulse == 0, "R8 no ovf while room", ovf_pulse, 0);
        post(6, 8'h09);
        chk(ovf_pulse == 1, "R8 ovf on full", ovf_pulse, 1);
        tick();
        chk(ovf_pulse == 0, "R8 ovf one cycle", ovf_pulse, 0);

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            post_en   = ($urandom_range(0, 99) < 40);
            post_lvl  = 3'($urandom_range(0, 7));
            post_vec  = 8'($urandom_range(0, 11));
            cur_pri   = 3'($urandom_range(0, 7));
            boundary  = ($urandom_range(0, 99) < 30);
            sel_ready = ($urandom_range(0, 99) < 50);
            tick();
        end
        post_en = 0; boundary = 0; sel_ready = 0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule